// File: doc/BRIEF.md
# Eight-Channel DMA Register Window

This block is the software-visible register file of an eight-channel DMA controller. A host reaches it through a plain 32-bit word bus made of an address, a write enable, write data and registered read data. It stores the programmed setup of every channel and passes each field out to the transfer engines. It also returns the live busy state of each engine on reads.

The window spans 4 KB, but only the low byte of the address takes part in decoding. Each 256-byte page therefore shows the same registers. One global control word sits at the bottom of the page. Seven-word channel blocks follow it, each 0x1C bytes long.

Writing a channel's source or destination address also reloads the working pointer that the engine advances. Writing the enable bit of a channel's control word sends a one-cycle start pulse to that engine.

Top module: `dma_regwin`

## Requirements
- R1: While rst_n is low at a clock edge, every stored register, working pointer, `bus_rdata` and `ch_start` become zero.
- R2: A read returns, one cycle after the address is presented, the register contents as they were at that clock edge. When a write and a read hit the same word in the same cycle, the read returns the value from before the write.
- R3: Address bits 11:8 and 1:0 are ignored, so the first 256 bytes repeat across the whole 4 KB window for both reads and writes.
- R4: The global control word is at offset 0x00. Channel n (0 to 7) starts at 0x04 + n*0x1C. Its words are, in order: source address, destination address, total count, per-event count, block/interval control, fill pattern, and channel control.
- R5: Source and destination address registers store bits 31:2 of the written data, and bits 1:0 read as zero.
- R6: Only these bits are implemented:
  - total count, bits 27:0;
  - per-event count, bits 23:0;
  - block/interval, bits 17:0;
  - global control, bits 31, 19:16 and 0 (mask 0x800F0001);
  - channel control, bits 30:0 under mask 0x7F0FFC1F.
  
  All other bits read as zero.
- R7: Offsets 0xE4 to 0xFF of each page read as zero, and writes to them change no register.
- R8: A bus write to a source or destination address loads the aligned value into that channel's working pointer (`ch_src_ptr`/`ch_dst_ptr`), visible the cycle after the write.
- R9: When `eng_adv[n]` is high, channel n's working pointers take `eng_src_next`/`eng_dst_next`. A bus write to the same address register in the same cycle takes priority over the engine value.
- R10: A write to a channel control word with bit 31 set raises `ch_start[n]` for exactly the cycle after the write. A write with bit 31 clear raises no pulse.
- R11: Bit 31 of a channel control read is `eng_busy[n]` as sampled at the read edge, not a stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address into the window |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_busy | input | 8 | Per-channel engine busy |
| eng_adv | input | 8 | Per-channel working pointer update strobe |
| eng_src_next | input | 256 | Next source pointer per channel |
| eng_dst_next | input | 256 | Next destination pointer per channel |
| glob_ctrl | output | 32 | Global control word |
| ch_start | output | 8 | One-cycle start pulse per channel |
| ch_src_ptr | output | 256 | Working source pointer per channel |
| ch_dst_ptr | output | 256 | Working destination pointer per channel |
| ch_total | output | 224 | Total word count per channel (28 bits each) |
| ch_wcount | output | 192 | Per-event word count per channel (24 bits each) |
| ch_blkctl | output | 144 | Interval and prescaler per channel (18 bits each) |
| ch_fill | output | 256 | Fill pattern per channel |
| ch_ctrl | output | 248 | Channel control bits 30:0 per channel |

## Verification
The main function is tried with all-ones data on every register kind, which exposes the implemented-bit masks. Unaligned address data shows that bits 1:0 are dropped. Addresses with high bits set are used to confirm mirroring. Writes to the first and last channel, and to the words just past the last channel, separate correct channel boundaries from off-by-one decoding. Directed cases set an engine update and a bus write against each other in the same cycle, read and write one word together, and toggle the busy input beneath a stored control word. Each of these tells a different priority or sampling error apart from correct behaviour.

// File: rtl/dma_regwin_pkg.sv
// Shared constants and types for the DMA register window.
// Assumes a 32-bit word bus; masks below are written for that width.
package dma_regwin_pkg;
    localparam int DATA_W     = 32;
    localparam int REGS_PER_CH = 7;
    localparam int TOTAL_W    = 28;
    localparam int WCNT_W     = 24;
    localparam int BLK_W      = 18;
    localparam int CTRL_W     = 31;
    localparam logic [DATA_W-1:0] GLOB_MASK = 32'h800F_0001;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 31'h7F0F_FC1F;

    // Word order inside a channel block; the decoder depends on it.
    typedef enum logic [2:0] {
        RI_SRC   = 3'd0,
        RI_DST   = 3'd1,
        RI_TOTAL = 3'd2,
        RI_WCNT  = 3'd3,
        RI_BLK   = 3'd4,
        RI_FILL  = 3'd5,
        RI_CTRL  = 3'd6
    } reg_idx_e;
endpackage

// File: rtl/dma_regwin_dec.sv
// Address decoder: maps the word index within a 256-byte page to the
// global word, one channel and a register index, or to nothing.
// Assumes 1 + NUM_CH*7 <= 64 so every channel fits in one page.
module dma_regwin_dec
    import dma_regwin_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [5:0]        word_idx,
    output logic              glob_sel,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_idx_e          reg_idx,
    output logic              valid
);
    // Compare the word index against each channel's seven-word range.
    always_comb begin
        ch_hit  = '0;
        reg_idx = RI_SRC;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(word_idx) >= 1 + c*REGS_PER_CH &&
                int'(word_idx) <  1 + (c+1)*REGS_PER_CH) begin
                ch_hit[c] = 1'b1;
                reg_idx   = reg_idx_e'(3'(int'(word_idx) - 1 - c*REGS_PER_CH));
            end
        end
    end

    // Global word lives at the page base; anything else unmatched is a hole.
    assign glob_sel = (word_idx == 6'd0);
    assign valid    = glob_sel | (|ch_hit);

    // R4: at most one target selected for any address.
    always_comb begin
        p_single_target_r4: assert ($onehot0({glob_sel, ch_hit}))
            else $error("decoder selected more than one target");
    end
endmodule

// File: rtl/dma_regwin_chan.sv
// One channel's register set: seven programmed words, working source and
// destination pointers, and the start pulse. Read data is combinational
// here; the top registers it. Assumes sel is one-hot across channels.
module dma_regwin_chan
    import dma_regwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  reg_idx_e           reg_idx,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               busy,
    input  logic               adv,
    input  logic [DATA_W-1:0]  src_next,
    input  logic [DATA_W-1:0]  dst_next,
    output logic [DATA_W-1:0]  rd_word,
    output logic [DATA_W-1:0]  src_ptr,
    output logic [DATA_W-1:0]  dst_ptr,
    output logic [TOTAL_W-1:0] total,
    output logic [WCNT_W-1:0]  wcount,
    output logic [BLK_W-1:0]   blkctl,
    output logic [DATA_W-1:0]  fill,
    output logic [CTRL_W-1:0]  ctrl,
    output logic               start
);
    logic              wr;
    logic [DATA_W-1:0] src_q, dst_q;

    assign wr = sel && we;

    // Programmed registers and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            total  <= '0;
            wcount <= '0;
            blkctl <= '0;
            fill   <= '0;
            ctrl   <= '0;
            start  <= 1'b0;
        end else begin
            start <= wr && (reg_idx == RI_CTRL) && wdata[DATA_W-1];
            if (wr) begin
                case (reg_idx)
                    RI_SRC:   src_q  <= {wdata[DATA_W-1:2], 2'b00};
                    RI_DST:   dst_q  <= {wdata[DATA_W-1:2], 2'b00};
                    RI_TOTAL: total  <= wdata[TOTAL_W-1:0];
                    RI_WCNT:  wcount <= wdata[WCNT_W-1:0];
                    RI_BLK:   blkctl <= wdata[BLK_W-1:0];
                    RI_FILL:  fill   <= wdata;
                    RI_CTRL:  ctrl   <= wdata[CTRL_W-1:0] & CTRL_MASK;
                    default:  ;
                endcase
            end
        end
    end

    // Working pointers: bus write first, engine advance second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
        end else begin
            if (wr && reg_idx == RI_SRC)      src_ptr <= {wdata[DATA_W-1:2], 2'b00};
            else if (adv)                     src_ptr <= src_next;
            if (wr && reg_idx == RI_DST)      dst_ptr <= {wdata[DATA_W-1:2], 2'b00};
            else if (adv)                     dst_ptr <= dst_next;
        end
    end

    // Read selection; control bit 31 reflects the engine, not storage.
    always_comb begin
        case (reg_idx)
            RI_SRC:   rd_word = src_q;
            RI_DST:   rd_word = dst_q;
            RI_TOTAL: rd_word = DATA_W'(total);
            RI_WCNT:  rd_word = DATA_W'(wcount);
            RI_BLK:   rd_word = DATA_W'(blkctl);
            RI_FILL:  rd_word = fill;
            RI_CTRL:  rd_word = {busy, ctrl};
            default:  rd_word = '0;
        endcase
    end

    // R8: a bus write of the source address appears aligned on the pointer.
    p_src_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_idx == RI_SRC) |=> (src_ptr == {$past(wdata[DATA_W-1:2]), 2'b00}))
        else $error("source pointer not loaded from bus");

    // R9: engine advance lands when no bus write targets the pointer.
    p_adv_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !(wr && reg_idx == RI_DST)) |=> (dst_ptr == $past(dst_next)))
        else $error("destination pointer missed engine update");

    // R10: a start pulse only ever follows a bus write cycle.
    p_start_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(we && sel))
        else $error("start pulse without a write");
endmodule

// File: rtl/dma_regwin.sv
// Top of the DMA register window. Decodes the low byte of the bus
// address (so the 256-byte page mirrors through the 4 KB window), holds
// the global control word, instantiates one register set per channel and
// registers the read data. Assumes word-sized accesses only.
module dma_regwin
    import dma_regwin_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_CH-1:0]         eng_busy,
    input  logic [NUM_CH-1:0]         eng_adv,
    input  logic [NUM_CH*DATA_W-1:0]  eng_src_next,
    input  logic [NUM_CH*DATA_W-1:0]  eng_dst_next,
    output logic [DATA_W-1:0]         glob_ctrl,
    output logic [NUM_CH-1:0]         ch_start,
    output logic [NUM_CH*DATA_W-1:0]  ch_src_ptr,
    output logic [NUM_CH*DATA_W-1:0]  ch_dst_ptr,
    output logic [NUM_CH*TOTAL_W-1:0] ch_total,
    output logic [NUM_CH*WCNT_W-1:0]  ch_wcount,
    output logic [NUM_CH*BLK_W-1:0]   ch_blkctl,
    output logic [NUM_CH*DATA_W-1:0]  ch_fill,
    output logic [NUM_CH*CTRL_W-1:0]  ch_ctrl
);
    localparam int PAGE_BITS = 8;

    logic              glob_sel, dec_valid;
    logic [NUM_CH-1:0] ch_hit;
    reg_idx_e          reg_idx;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] rd_next;
    logic              addr_unused;

    // Bits outside the page and the byte lane are deliberately ignored.
    assign addr_unused = ^{bus_addr[ADDR_W-1:PAGE_BITS], bus_addr[1:0]};

    dma_regwin_dec #(.NUM_CH(NUM_CH)) dec_i (
        .word_idx (bus_addr[PAGE_BITS-1:2]),
        .glob_sel (glob_sel),
        .ch_hit   (ch_hit),
        .reg_idx  (reg_idx),
        .valid    (dec_valid)
    );

    // Global control word with only its implemented bits kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                  glob_ctrl <= '0;
        else if (bus_we && glob_sel) glob_ctrl <= bus_wdata & GLOB_MASK;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_regwin_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (ch_hit[c]),
            .reg_idx  (reg_idx),
            .we       (bus_we),
            .wdata    (bus_wdata),
            .busy     (eng_busy[c]),
            .adv      (eng_adv[c]),
            .src_next (eng_src_next[c*DATA_W +: DATA_W]),
            .dst_next (eng_dst_next[c*DATA_W +: DATA_W]),
            .rd_word  (ch_rd[c]),
            .src_ptr  (ch_src_ptr[c*DATA_W +: DATA_W]),
            .dst_ptr  (ch_dst_ptr[c*DATA_W +: DATA_W]),
            .total    (ch_total[c*TOTAL_W +: TOTAL_W]),
            .wcount   (ch_wcount[c*WCNT_W +: WCNT_W]),
            .blkctl   (ch_blkctl[c*BLK_W +: BLK_W]),
            .fill     (ch_fill[c*DATA_W +: DATA_W]),
            .ctrl     (ch_ctrl[c*CTRL_W +: CTRL_W]),
            .start    (ch_start[c])
        );
    end

    // Read multiplexer: OR of the selected source, zero for holes.
    always_comb begin
        rd_next = glob_sel ? glob_ctrl : '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) rd_next = rd_next | ch_rd[c];
        end
    end

    // Register read data one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    // R7: an address that decodes to no register reads back as zero.
    p_hole_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> (bus_rdata == '0))
        else $error("hole returned nonzero data");

    // R6: global control never shows bits outside its implemented set.
    p_glob_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && glob_sel) |-> ((glob_ctrl & ~GLOB_MASK) == '0))
        else $error("global control holds unimplemented bits");
endmodule

// File: tb/dma_regwin_tb_top.sv
`timescale 1ns/1ps
module dma_regwin_tb_top;
    localparam int NCH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    eng_busy = '0;
    logic [NCH-1:0]    eng_adv = '0;
    logic [NCH*32-1:0] eng_src_next = '0;
    logic [NCH*32-1:0] eng_dst_next = '0;
    logic [31:0]       glob_ctrl;
    logic [NCH-1:0]    ch_start;
    logic [NCH*32-1:0] ch_src_ptr, ch_dst_ptr, ch_fill;
    logic [NCH*28-1:0] ch_total;
    logic [NCH*24-1:0] ch_wcount;
    logic [NCH*18-1:0] ch_blkctl;
    logic [NCH*31-1:0] ch_ctrl;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    dma_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
        .eng_adv(eng_adv), .eng_src_next(eng_src_next),
        .eng_dst_next(eng_dst_next), .glob_ctrl(glob_ctrl),
        .ch_start(ch_start), .ch_src_ptr(ch_src_ptr), .ch_dst_ptr(ch_dst_ptr),
        .ch_total(ch_total), .ch_wcount(ch_wcount), .ch_blkctl(ch_blkctl),
        .ch_fill(ch_fill), .ch_ctrl(ch_ctrl)
    );

    typedef struct packed {
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{12'h004, 32'h1234_5677, 12'h004, 32'h1234_5674, 8'd5},  // R5 ch0 src aligned
        '{12'h008, 32'hFFFF_FFFF, 12'h108, 32'hFFFF_FFFC, 8'd3},  // R3 mirror read
        '{12'h00C, 32'hFFFF_FFFF, 12'h00C, 32'h0FFF_FFFF, 8'd6},  // R6 total 28 bits
        '{12'h010, 32'hFFFF_FFFF, 12'h010, 32'h00FF_FFFF, 8'd6},  // R6 count 24 bits
        '{12'h014, 32'hFFFF_FFFF, 12'h014, 32'h0003_FFFF, 8'd6},  // R6 block 18 bits
        '{12'h018, 32'hDEAD_BEEF, 12'h918, 32'hDEAD_BEEF, 8'd3},  // R3 fill via mirror
        '{12'h01C, 32'h7FFF_FFFF, 12'h01C, 32'h7F0F_FC1F, 8'd6},  // R6 control mask
        '{12'h000, 32'hFFFF_FFFF, 12'hF00, 32'h800F_0001, 8'd6},  // R6 global mask
        '{12'h0E0, 32'h0000_0003, 12'h0E0, 32'h0000_0003, 8'd4},  // R4 ch7 control
        '{12'h3C8, 32'hA5A5_A5A5, 12'h0C8, 32'hA5A5_A5A4, 8'd4},  // R4 ch7 source
        '{12'h0E4, 32'hFFFF_FFFF, 12'h0E4, 32'h0000_0000, 8'd7},  // R7 first hole
        '{12'h0FC, 32'hFFFF_FFFF, 12'h0FC, 32'h0000_0000, 8'd7},  // R7 last hole
        '{12'h0E8, 32'hFFFF_FFFF, 12'h01C, 32'h7F0F_FC1F, 8'd7},  // R7 hole write harmless
        '{12'h56C, 32'h0BAD_F00D, 12'h06C, 32'h0BAD_F00D, 8'd4},  // R4 ch3 fill
        '{12'h020, 32'h0000_0001, 12'h020, 32'h0000_0000, 8'd4}   // R4 ch1 source base
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(12'h004, rd);
        check("R1 rdata", rd, 32'h0);
        check("R1 src ptr", ch_src_ptr[31:0], 32'h0);
        check("R1 start", 32'(ch_start), 32'h0);
        check("R1 global", glob_ctrl, 32'h0);

        // Table walk: write, then read back.
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i].waddr, VEC[i].wdata);
            bus_read(VEC[i].raddr, rd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].expv);
        end
        check("R6 global port", glob_ctrl, 32'h800F_0001);
        check("R6 ch0 ctrl port", 32'(ch_ctrl[30:0]), 32'h7F0F_FC1F);

        // R2: simultaneous write and read returns the old value.
        bus_write(12'h06C, 32'h1111_1111);
        check("R2 old value", bus_rdata, 32'h0BAD_F00D);
        @(negedge clk);
        check("R2 new value", bus_rdata, 32'h1111_1111);

        // R8: working pointers follow bus writes.
        bus_write(12'h078, 32'hCAFE_0007);
        check("R8 dst ptr ch4", ch_dst_ptr[4*32 +: 32], 32'hCAFE_0004);
        check("R8 ch1 src ptr", ch_src_ptr[1*32 +: 32], 32'h0);
        check("R8 ch7 src ptr", ch_src_ptr[7*32 +: 32], 32'hA5A5_A5A4);

        // R9: engine advance, then conflict where the bus wins.
        @(negedge clk);
        eng_adv[4] = 1'b1;
        eng_src_next[4*32 +: 32] = 32'h0000_1000;
        eng_dst_next[4*32 +: 32] = 32'h0000_2000;
        @(negedge clk);
        eng_adv[4] = 1'b0;
        check("R9 src advance", ch_src_ptr[4*32 +: 32], 32'h0000_1000);
        check("R9 dst advance", ch_dst_ptr[4*32 +: 32], 32'h0000_2000);
        bus_read(12'h074, rd);
        check("R9 programmed src kept", rd, 32'h0);
        bus_addr = 12'h074; bus_wdata = 32'h2222_2223; bus_we = 1'b1;
        eng_adv[4] = 1'b1;
        eng_src_next[4*32 +: 32] = 32'h0000_5555;
        @(negedge clk);
        bus_we = 1'b0; eng_adv[4] = 1'b0;
        check("R9 bus wins src", ch_src_ptr[4*32 +: 32], 32'h2222_2220);
        check("R9 dst still advances", ch_dst_ptr[4*32 +: 32], 32'h0000_2000);

        // R10: start pulse for one cycle only when bit 31 is written.
        bus_write(12'h054, 32'h8000_0001);
        check("R10 start high", 32'(ch_start), 32'h0000_0004);
        @(negedge clk);
        check("R10 start one cycle", 32'(ch_start), 32'h0);
        bus_write(12'h054, 32'h0000_0002);
        check("R10 no start", 32'(ch_start), 32'h0);

        // R11: busy bit read live from the engine.
        eng_busy[2] = 1'b1;
        bus_read(12'h054, rd);
        check("R11 busy set", rd, 32'h8000_0002);
        eng_busy[2] = 1'b0;
        bus_read(12'h054, rd);
        check("R11 busy clear", rd, 32'h0000_0002);

        // R1: reset mid-run clears stored state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(12'h018, rd);
        check("R1 fill cleared", rd, 32'h0);
        check("R1 ptr cleared", ch_dst_ptr[4*32 +: 32], 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule